// File: doc/BRIEF.md
# Dual-Bank I/O Bit-Field Access Unit

The unit keeps two byte-wide output vector latches, a left bank and a right bank, and gives bit-field access to either one. An extract request reads a field of one to eight bits from the selected bank and returns it right-aligned. A merge request writes a value into a field of the selected bank. The merge is a read-modify-write, so every latch bit outside the field keeps its value. Each bank drives its own output port and raises a write strobe each time a merge writes to it.

A field is addressed by a 3-bit position and a 3-bit length code. The position is counted from the most significant bit, so position 7 names bit 0 of the byte. The field's least significant bit sits at bit (7 − position). A length code of zero means a full eight-bit field.

Extraction rotates the byte, so a field can wrap past bit 7 back into bit 0. Merging shifts the value and its mask, so any field bits that would land above bit 7 are dropped.

Top module: `iofield_unit`

## Requirements
- R1: While the synchronous active-low reset is applied, both latches, both write strobes and the extract output are cleared at the next clock edge.
- R2: Length code 0 selects an 8-bit field and code n (1..7) selects n bits. Extract output bits at and above the field length are always 0.
- R3: Extracted value = the selected bank's byte rotated right by (7 − position), keeping the low length bits. A field whose length exceeds (position + 1) wraps from bit 7 into bit 0.
- R4: The extract output takes its new value at the clock edge where the extract strobe is high, and holds its value at every other edge.
- R5: A merge with mask m = (length ones) << (7 − position), truncated to 8 bits, sets the addressed latch to (old & ~m) | ((value << (7 − position)) & m) at the clock edge.
- R6: Bank select 0 addresses the left bank and 1 the right bank. A merge leaves the other bank's latch unchanged.
- R7: A bank's write strobe is high for exactly the cycle after each edge that merged into that bank. It is high while the new latch value is first visible and low otherwise.
- R8: An extract and a merge to the same bank at the same edge return the latch value from before the merge.
- R9: Bits of the merge value at or above the field length have no effect on the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| xt_en | input | 1 | Extract request |
| xt_bank | input | 1 | Extract bank select (0 left, 1 right) |
| xt_pos | input | 3 | Extract field position from MSB |
| xt_len | input | 3 | Extract length code (0 = 8 bits) |
| mg_en | input | 1 | Merge request |
| mg_bank | input | 1 | Merge bank select (0 left, 1 right) |
| mg_pos | input | 3 | Merge field position from MSB |
| mg_len | input | 3 | Merge length code (0 = 8 bits) |
| mg_val | input | 8 | Right-aligned value to merge |
| field_out | output | 8 | Right-aligned extracted field |
| left_q | output | 8 | Left bank latch / output port |
| right_q | output | 8 | Right bank latch / output port |
| left_wr | output | 1 | Left port write strobe |
| right_wr | output | 1 | Right port write strobe |

## Verification
The hardest case to reach from the ports is a wrapping extract that hits the same bank as a merge on the same edge. In that case the returned field has to mix pre-merge bits from both ends of the byte. Directed steps first load known patterns and then issue wrapping extracts, both alone and together with merges to the same bank. Several hundred random cycles with a fixed seed then mix bank selects, positions, lengths and strobes. In these cycles a collision happens often, and the merge values carry stray high bits.

// File: rtl/iof_pkg.sv
// Shared constants, types and helpers for the I/O bit-field unit.
// Assumes a byte-wide latch; field codes are log2 of that width.
package iof_pkg;
    parameter int unsigned IOF_W  = 8;
    localparam int unsigned IOF_PW = $clog2(IOF_W);

    typedef logic [IOF_W-1:0]  iof_byte_t;
    typedef logic [IOF_PW-1:0] iof_code_t;

    localparam int unsigned IOF_BANKS = 2;

    // Ones in the low 'code' bits; code 0 means the full width.
    function automatic iof_byte_t iof_ones(input iof_code_t code);
        iof_byte_t r;
        if (code == '0) r = '1;
        else            r = iof_byte_t'((1 << code) - 1);
        return r;
    endfunction
endpackage

// File: rtl/field_extract.sv
// Combinational field extraction: rotates the source right so the field's
// LSB lands at bit 0, then masks to the coded length. Assumes position is
// counted from the MSB.
module field_extract
    import iof_pkg::*;
(
    input  iof_byte_t src,
    input  iof_code_t pos,
    input  iof_code_t len,
    output iof_byte_t field
);
    localparam iof_code_t TOP = iof_code_t'(IOF_W - 1);

    iof_code_t         rot;
    logic [2*IOF_W-1:0] dbl;

    // Rotate by doubling the byte and shifting; the low half is the rotation.
    always_comb begin
        rot   = TOP - pos;
        dbl   = {src, src} >> rot;
        field = dbl[IOF_W-1:0] & iof_ones(len);
    end
endmodule

// File: rtl/field_merge.sv
// Combinational read-modify-write merge: shifts value and length mask left
// to the field position and keeps all other bits of the old byte.
// Bits pushed past the MSB are discarded.
module field_merge
    import iof_pkg::*;
(
    input  iof_byte_t old_q,
    input  iof_byte_t value,
    input  iof_code_t pos,
    input  iof_code_t len,
    output iof_byte_t mask,
    output iof_byte_t merged
);
    localparam iof_code_t TOP = iof_code_t'(IOF_W - 1);

    iof_code_t sh;

    // Place mask and value, then splice into the old byte.
    always_comb begin
        sh     = TOP - pos;
        mask   = iof_ones(len) << sh;
        merged = (old_q & ~mask) | ((value << sh) & mask);
    end
endmodule

// File: rtl/bank_latch.sv
// One output vector latch with its port write strobe. The strobe is high
// for the cycle after every write. Assumes synchronous active-low reset.
module bank_latch
    import iof_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  iof_byte_t wr_data,
    output iof_byte_t q,
    output logic      strobe
);
    // Latch register and strobe register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            strobe <= 1'b0;
        end else begin
            if (wr_en) q <= wr_data;
            strobe <= wr_en;
        end
    end

    assert_strobe_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> strobe);
    assert_strobe_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !strobe);
    assert_hold_without_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));
endmodule

// File: rtl/iofield_unit.sv
// Dual-bank I/O bit-field access unit. Extracts a right-aligned field from
// either bank (registered) and merges fields into either bank. An extract
// at the same edge as a merge sees the pre-merge latch value.
module iofield_unit
    import iof_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xt_en,
    input  logic       xt_bank,
    input  logic [2:0] xt_pos,
    input  logic [2:0] xt_len,
    input  logic       mg_en,
    input  logic       mg_bank,
    input  logic [2:0] mg_pos,
    input  logic [2:0] mg_len,
    input  logic [7:0] mg_val,
    output logic [7:0] field_out,
    output logic [7:0] left_q,
    output logic [7:0] right_q,
    output logic       left_wr,
    output logic       right_wr
);
    iof_byte_t bank_q  [IOF_BANKS];
    logic      bank_wr [IOF_BANKS];
    iof_byte_t xt_src, xt_field, mg_old, mg_mask, mg_new;

    // Select source bytes for the two datapaths.
    always_comb begin
        xt_src = bank_q[xt_bank];
        mg_old = bank_q[mg_bank];
    end

    field_extract u_ext (
        .src(xt_src), .pos(xt_pos), .len(xt_len), .field(xt_field)
    );

    field_merge u_mrg (
        .old_q(mg_old), .value(mg_val), .pos(mg_pos), .len(mg_len),
        .mask(mg_mask), .merged(mg_new)
    );

    generate
        for (genvar g = 0; g < IOF_BANKS; g++) begin : g_bank
            bank_latch u_bank (
                .clk(clk), .rst_n(rst_n),
                .wr_en(mg_en && (mg_bank == 1'(g))),
                .wr_data(mg_new),
                .q(bank_q[g]), .strobe(bank_wr[g])
            );
        end
    endgenerate

    // Extract result register; holds between requests.
    always_ff @(posedge clk) begin
        if (!rst_n)     field_out <= '0;
        else if (xt_en) field_out <= xt_field;
    end

    assign left_q   = bank_q[0];
    assign right_q  = bank_q[1];
    assign left_wr  = bank_wr[0];
    assign right_wr = bank_wr[1];

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (left_q == 8'h00 && right_q == 8'h00 && !left_wr && !right_wr
                    && field_out == 8'h00));
    assert_field_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xt_en |=> ((field_out & ~iof_ones($past(xt_len))) == 8'h00));
    assert_hold_output_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !xt_en |=> $stable(field_out));
    assert_keep_outside_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_en && !mg_bank) |=> (((left_q ^ $past(left_q)) & ~$past(mg_mask)) == 8'h00));
    assert_keep_outside_right_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_en && mg_bank) |=> (((right_q ^ $past(right_q)) & ~$past(mg_mask)) == 8'h00));
    assert_other_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_en && !mg_bank) |=> $stable(right_q));
    assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({left_wr, right_wr}) <= 1);
endmodule

// File: tb/sim_iofield_unit.sv
module sim_iofield_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xt_en = 1'b0, xt_bank = 1'b0, mg_en = 1'b0, mg_bank = 1'b0;
    logic [2:0] xt_pos = '0, xt_len = '0, mg_pos = '0, mg_len = '0;
    logic [7:0] mg_val = '0;
    logic [7:0] field_out, left_q, right_q;
    logic       left_wr, right_wr;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    logic [7:0] m_bank [2];
    logic [7:0] m_field;
    logic       m_wr [2];

    always #10 clk = ~clk;

    iofield_unit u0 (
        .clk(clk), .rst_n(rst_n), .xt_en(xt_en), .xt_bank(xt_bank),
        .xt_pos(xt_pos), .xt_len(xt_len), .mg_en(mg_en), .mg_bank(mg_bank),
        .mg_pos(mg_pos), .mg_len(mg_len), .mg_val(mg_val),
        .field_out(field_out), .left_q(left_q), .right_q(right_q),
        .left_wr(left_wr), .right_wr(right_wr)
    );

    function automatic int nbits(input logic [2:0] code);
        return (code == 0) ? 8 : int'(code);
    endfunction

    function automatic logic [7:0] ref_extract(input logic [7:0] b, input logic [2:0] pos,
                                               input logic [2:0] len);
        logic [7:0] r = '0;
        for (int i = 0; i < nbits(len); i++) r[i] = b[(7 - int'(pos) + i) % 8];
        return r;
    endfunction

    function automatic logic [7:0] ref_merge(input logic [7:0] old, input logic [7:0] v,
                                             input logic [2:0] pos, input logic [2:0] len);
        logic [7:0] r = old;
        for (int i = 0; i < nbits(len); i++) begin
            int idx = 7 - int'(pos) + i;
            if (idx < 8) r[idx] = v[i];
        end
        return r;
    endfunction

    task automatic check(input string req, input string what, input logic [7:0] act,
                         input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // Advance one clock with the current inputs, update model, check outputs.
    task automatic step(input string req);
        @(posedge clk);
        if (!rst_n) begin
            m_bank[0] = '0; m_bank[1] = '0; m_field = '0; m_wr[0] = 0; m_wr[1] = 0;
        end else begin
            if (xt_en) m_field = ref_extract(m_bank[xt_bank], xt_pos, xt_len);
            m_wr[0] = mg_en && !mg_bank;
            m_wr[1] = mg_en && mg_bank;
            if (mg_en) m_bank[mg_bank] = ref_merge(m_bank[mg_bank], mg_val, mg_pos, mg_len);
        end
        @(negedge clk);
        check(req, "field_out", field_out, m_field);
        check(req, "left_q", left_q, m_bank[0]);
        check(req, "right_q", right_q, m_bank[1]);
        check("R7", "left_wr", {7'd0, left_wr}, {7'd0, m_wr[0]});
        check("R7", "right_wr", {7'd0, right_wr}, {7'd0, m_wr[1]});
    endtask

    task automatic drive(input bit xe, input bit xb, input int xp, input int xl,
                         input bit me, input bit mb, input int mp, input int ml,
                         input int mv);
        xt_en = xe; xt_bank = xb; xt_pos = 3'(xp); xt_len = 3'(xl);
        mg_en = me; mg_bank = mb; mg_pos = 3'(mp); mg_len = 3'(ml); mg_val = 8'(mv);
    endtask

    initial begin
        void'($urandom(32'd1234));
        m_bank[0] = '0; m_bank[1] = '0; m_field = '0; m_wr[0] = 0; m_wr[1] = 0;
        // R1: hold reset with active requests; all must clear.
        drive(1, 0, 7, 0, 1, 0, 7, 0, 8'hFF);
        step("R1"); step("R1");
        rst_n = 1'b1;
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R1");
        // R5 full byte merge left, R6 right stays clear.
        drive(0, 0, 0, 0, 1, 0, 7, 0, 8'hA5); step("R5");
        drive(0, 0, 0, 0, 1, 1, 7, 0, 8'h3C); step("R6");
        // R2/R3 full-byte extract, then a wrapping 2-bit field (expect 3).
        drive(1, 0, 7, 0, 0, 0, 0, 0, 0); step("R2");
        drive(1, 0, 0, 2, 0, 0, 0, 0, 0); step("R3");
        // R3 wrap across boundary, 8-bit from position 3.
        drive(1, 1, 3, 0, 0, 0, 0, 0, 0); step("R3");
        // R4 extract output holds while idle and during merges.
        drive(0, 1, 0, 1, 1, 1, 4, 3, 8'h05); step("R4");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0); step("R4");
        // R9 stray high bits in merge value; R5 field dropping past MSB.
        drive(0, 0, 0, 0, 1, 0, 5, 2, 8'hFC); step("R9");
        drive(0, 0, 0, 0, 1, 1, 0, 4, 8'h0F); step("R5");
        // R8 extract and merge same bank same edge: old value returned.
        drive(1, 0, 7, 0, 1, 0, 7, 0, 8'h00); step("R8");
        drive(1, 1, 1, 5, 1, 1, 2, 6, 8'h6B); step("R8");
        drive(1, 0, 7, 0, 0, 0, 0, 0, 0); step("R8");
        // Random mix.
        for (int n = 0; n < 600; n++) begin
            drive($urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1,
                  $urandom_range(7, 0), $urandom_range(7, 0),
                  $urandom_range(3, 0) != 0, $urandom_range(1, 0) == 1,
                  $urandom_range(7, 0), $urandom_range(7, 0), $urandom_range(255, 0));
            step("R3");
        end
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R7");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(20 * 50000);
        if (!done) begin
            vectors++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule